// File: doc/BRIEF.md
# Filtered receive message logger

This block records messages arriving from several senders. Each message is a 16-bit data word plus the 8-bit index of the channel it came from. A filter register holds an 8-bit channel pattern and an 8-bit care mask. The block stores a message only when every channel bit selected by the mask equals the matching pattern bit. Stored messages go into a 4096-word memory in arrival order. A write pointer marks where the next stored message will land and wraps at the end of the memory.

Software reaches the filter, the pointer and the memory through a simple register port. A read presented in one cycle returns its data, with a valid strobe, in the next cycle. Software may also write memory words, for example to preload or clear the log. When a message capture and a software memory write fall in the same cycle, the capture takes the memory port. The pointer is visible to software but cannot be written.

Top module: `rx_msg_logger`

## Requirements
- R1: A synchronous active-high reset sets the write pointer to 0 and the filter register to 0x0000, so that every message is accepted after reset.
- R2: The filter register sits at register address 0x0000, with the pattern in bits 7-0 and the care mask in bits 15-8. A valid message is accepted exactly when ((channel XOR pattern) AND mask) is zero, so a zero mask accepts every channel.
- R3: An accepted message's data is written to the memory word addressed by the current pointer, and the pointer shows that value plus one from the following cycle.
- R4: The pointer wraps from 4095 to 0.
- R5: A rejected message changes neither the pointer nor any memory word.
- R6: Register addresses are 13 bits wide. With bit 12 set, bits 11-0 select a memory word. With bit 12 clear, 0x0000 is the filter, 0x0001 is the pointer (zero-extended) and every other address reads 0. A read strobe in cycle t gives the data and a high read-valid in cycle t+1, and read-valid is low after any cycle without a read strobe.
- R7: A software write into the memory window stores the word. A software write to the pointer address has no effect.
- R8: When an accepted message and a software memory write occur in the same cycle, the message is stored at the pointer and the software write is discarded, whatever its address.
- R9: A filter write applies to messages from the next cycle on. A message arriving in the same cycle as a filter write is judged by the old filter.
- R10: A read of a memory word in the same cycle as that word is written returns the previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| msg_valid | input | 1 | A message is present this cycle |
| msg_chan | input | 8 | Channel index of the sender |
| msg_data | input | 16 | Message data word |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 13 | Register address (bit 12 selects the memory window) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, one cycle after the read strobe |
| reg_rvalid | output | 1 | Read data is valid |
| wr_ptr | output | 12 | Memory address of the next stored message |

## Verification
Message capture can coincide with software register traffic in the same cycle. This covers three cases: an accepted message together with a software memory write, aimed either at the pointer's word or at another word; a message together with a filter write; and a message together with a read of the very word being filled. The bench drives each of these pairs in a single cycle. A behavioural reference model applies the rules in a fixed order: the read sees the old contents, the filter decision uses the old filter, and the capture wins the memory port. The bench then compares the pointer, the read-valid strobe and the read data on every clock, and reads the affected words back afterwards.

// File: rtl/rxl_pkg.sv
package rxl_pkg;

    localparam int unsigned CHAN_W_DEF = 8;
    localparam int unsigned DATA_W_DEF = 16;
    localparam int unsigned ADDR_W_DEF = 12;

    // Register offsets inside the control window (address bit AW clear)
    localparam int unsigned OFS_FILTER = 0;
    localparam int unsigned OFS_WPTR   = 1;

endpackage

// File: rtl/rxl_filter.sv
module rxl_filter #(
    parameter int unsigned CHAN_W = 8
) (
    input  logic              msg_valid,
    input  logic [CHAN_W-1:0] msg_chan,
    input  logic [CHAN_W-1:0] pattern,
    input  logic [CHAN_W-1:0] care,
    output logic              hit
);

    logic [CHAN_W-1:0] bit_miss;

    // one comparator per channel bit; a bit only counts when its care bit is set
    for (genvar gi = 0; gi < CHAN_W; gi++) begin : g_bit
        assign bit_miss[gi] = care[gi] & (msg_chan[gi] ^ pattern[gi]);
    end

    assign hit = msg_valid & ~(|bit_miss);

endmodule

// File: rtl/rxl_ptr.sv
module rxl_ptr #(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          adv,
    output logic [AW-1:0] ptr
);

    typedef struct packed {
        logic [AW-1:0] ptr;
    } ptr_st_t;

    ptr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d.ptr = st_q.ptr + 1'b1;   // natural wrap at 2**AW
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr = st_q.ptr;

    AST_PTR_RESET: assert property (@(posedge clk) rst |=> (ptr == '0));                                            // R1
    AST_PTR_STEP:  assert property (@(posedge clk) disable iff (rst) adv |=> (ptr == AW'($past(ptr) + 1'b1)));       // R3
    AST_PTR_HOLD:  assert property (@(posedge clk) disable iff (rst) !adv |=> $stable(ptr));                         // R5

endmodule

// File: rtl/rxl_mem.sv
module rxl_mem #(
    parameter int unsigned AW = 12,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    typedef struct packed {
        logic [DW-1:0] rdata;
    } mem_st_t;

    logic [DW-1:0] store [DEPTH];
    mem_st_t       st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (re) begin
            st_d.rdata = store[raddr];    // old contents: write lands at the same edge
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = st_q.rdata;

endmodule

// File: rtl/rx_msg_logger.sv
module rx_msg_logger
    import rxl_pkg::*;
#(
    parameter int unsigned CHAN_W = CHAN_W_DEF,
    parameter int unsigned DATA_W = DATA_W_DEF,
    parameter int unsigned AW     = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msg_valid,
    input  logic [CHAN_W-1:0] msg_chan,
    input  logic [DATA_W-1:0] msg_data,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [AW:0]       reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic [AW-1:0]     wr_ptr
);

    localparam int unsigned FILT_W = 2 * CHAN_W;

    typedef struct packed {
        logic [CHAN_W-1:0] care;
        logic [CHAN_W-1:0] pattern;
    } filt_t;

    typedef struct packed {
        filt_t             filt;
        logic              rvalid;
        logic              rsel_mem;
        logic [DATA_W-1:0] rdata_ctl;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              sel_mem;
    logic [AW-1:0]     ofs;
    logic              accept;
    logic              filt_wr;
    logic              mem_we;
    logic [AW-1:0]     mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_re;
    logic [DATA_W-1:0] mem_rdata;

    assign sel_mem = reg_addr[AW];
    assign ofs     = reg_addr[AW-1:0];
    assign filt_wr = reg_wr_en & ~sel_mem & (ofs == AW'(OFS_FILTER));

    rxl_filter #(.CHAN_W(CHAN_W)) u_filter (
        .msg_valid (msg_valid),
        .msg_chan  (msg_chan),
        .pattern   (st_q.filt.pattern),
        .care      (st_q.filt.care),
        .hit       (accept)
    );

    rxl_ptr #(.AW(AW)) u_ptr (
        .clk (clk),
        .rst (rst),
        .adv (accept),
        .ptr (wr_ptr)
    );

    // capture owns the single write port; a coinciding software write is dropped
    always_comb begin
        mem_we    = accept | (reg_wr_en & sel_mem);
        mem_waddr = accept ? wr_ptr : ofs;
        mem_wdata = accept ? msg_data : reg_wdata;
        mem_re    = reg_rd_en & sel_mem;
    end

    rxl_mem #(.AW(AW), .DW(DATA_W)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .re    (mem_re),
        .raddr (ofs),
        .rdata (mem_rdata)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rvalid   = reg_rd_en;
        st_d.rsel_mem = sel_mem;
        if (filt_wr) begin
            st_d.filt = filt_t'(reg_wdata[FILT_W-1:0]);
        end
        if (reg_rd_en) begin
            st_d.rdata_ctl = '0;
            if (!sel_mem) begin
                if (ofs == AW'(OFS_FILTER)) begin
                    st_d.rdata_ctl[FILT_W-1:0] = st_q.filt;
                end else if (ofs == AW'(OFS_WPTR)) begin
                    st_d.rdata_ctl[AW-1:0] = wr_ptr;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign reg_rvalid = st_q.rvalid;
    assign reg_rdata  = st_q.rsel_mem ? mem_rdata : st_q.rdata_ctl;

    AST_FILT_RESET:  assert property (@(posedge clk) rst |=> (st_q.filt == '0));                                      // R1
    AST_OPEN_FILTER: assert property (@(posedge clk) disable iff (rst) (msg_valid && st_q.filt.care == '0) |-> accept); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst) !msg_valid |-> !accept);                          // R5
    AST_RD_LATENCY:  assert property (@(posedge clk) disable iff (rst) reg_rd_en |=> reg_rvalid);                        // R6
    AST_RD_IDLE:     assert property (@(posedge clk) disable iff (rst) !reg_rd_en |=> !reg_rvalid);                      // R6
    AST_FILT_HOLD:   assert property (@(posedge clk) disable iff (rst) !filt_wr |=> $stable(st_q.filt));                 // R9

endmodule

// File: tb/rx_msg_logger_tb.sv
`timescale 1ns/1ps
module rx_msg_logger_tb_top;

    localparam int DEPTH = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        msg_valid = 1'b0;
    logic [7:0]  msg_chan = '0;
    logic [15:0] msg_data = '0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [12:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        reg_rvalid;
    logic [11:0] wr_ptr;

    int n_checks = 0;
    int n_errors = 0;

    // reference model state
    logic [15:0] m_mem   [DEPTH];
    bit          m_known [DEPTH];
    int          m_ptr  = 0;
    logic [15:0] m_filt = 16'h0000;

    always #4 clk = ~clk;

    rx_msg_logger dut_i (
        .clk        (clk),
        .rst        (rst),
        .msg_valid  (msg_valid),
        .msg_chan   (msg_chan),
        .msg_data   (msg_data),
        .reg_wr_en  (reg_wr_en),
        .reg_rd_en  (reg_rd_en),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .wr_ptr     (wr_ptr)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // One clock: drive inputs, advance the model, compare outputs after the edge.
    task automatic step(input string tag, input bit v, input logic [7:0] ch, input logic [15:0] d,
                        input bit we, input bit re, input logic [12:0] a, input logic [15:0] wd);
        logic [15:0] exp_rd;
        bit          exp_known;
        bit          acc;
        msg_valid = v; msg_chan = ch; msg_data = d;
        reg_wr_en = we; reg_rd_en = re; reg_addr = a; reg_wdata = wd;
        exp_rd = '0;
        exp_known = 1'b1;
        if (re) begin
            if (a[12]) begin
                exp_rd = m_mem[a[11:0]];
                exp_known = m_known[a[11:0]];
            end else if (a[11:0] == 12'd0) begin
                exp_rd = m_filt;
            end else if (a[11:0] == 12'd1) begin
                exp_rd = 16'(m_ptr);
            end
        end
        acc = v && (((ch ^ m_filt[7:0]) & m_filt[15:8]) == 8'h00);
        if (acc) begin
            m_mem[m_ptr] = d;
            m_known[m_ptr] = 1'b1;
            m_ptr = (m_ptr + 1) % DEPTH;
        end else if (we && a[12]) begin
            m_mem[a[11:0]] = wd;
            m_known[a[11:0]] = 1'b1;
        end
        if (we && !a[12] && a[11:0] == 12'd0) m_filt = wd;
        @(posedge clk);
        @(negedge clk);
        chk(tag, "wr_ptr", 32'(wr_ptr), 32'(m_ptr));
        chk("R6", "reg_rvalid", 32'(reg_rvalid), 32'(re));
        if (re && exp_known) chk(tag, "reg_rdata", 32'(reg_rdata), 32'(exp_rd));
    endtask

    task automatic msg(input string tag, input logic [7:0] ch, input logic [15:0] d);
        step(tag, 1'b1, ch, d, 1'b0, 1'b0, 13'h0, 16'h0);
    endtask
    task automatic wr(input string tag, input logic [12:0] a, input logic [15:0] wd);
        step(tag, 1'b0, 8'h0, 16'h0, 1'b1, 1'b0, a, wd);
    endtask
    task automatic rd(input string tag, input logic [12:0] a);
        step(tag, 1'b0, 8'h0, 16'h0, 1'b0, 1'b1, a, 16'h0);
    endtask

    initial begin
        #(200000 * 8);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int p0;
        for (int i = 0; i < DEPTH; i++) m_known[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1", "wr_ptr after reset", 32'(wr_ptr), 32'd0);
        chk("R1", "reg_rvalid after reset", 32'(reg_rvalid), 32'd0);
        rd("R1", 13'h0000);

        // R2: open filter accepts any channel
        msg("R2", 8'h00, 16'h1111);
        msg("R2", 8'h7F, 16'h2222);
        msg("R2", 8'hFF, 16'h3333);
        msg("R2", 8'h13, 16'h4444);
        chk("R2", "pointer after four open captures", 32'(wr_ptr), 32'd4);

        // R3: stored in order at consecutive words
        for (int i = 0; i < 4; i++) rd("R3", 13'h1000 | 13'(i));

        // R6: pointer and unmapped reads
        rd("R6", 13'h0001);
        rd("R6", 13'h0005);
        step("R6", 1'b0, 8'h0, 16'h0, 1'b0, 1'b0, 13'h0000, 16'h0);

        // R2/R5: exact-match filter
        wr("R9", 13'h0000, 16'hFF5A);
        rd("R9", 13'h0000);
        msg("R2", 8'h5A, 16'hA5A5);
        p0 = m_ptr;
        wr("R7", 13'h1000 | 13'(p0), 16'hBEEF);
        msg("R5", 8'h5B, 16'hDEAD);
        msg("R5", 8'hDA, 16'hDEAD);
        rd("R5", 13'h1000 | 13'(p0));

        // R2: partial mask on the upper nibble
        wr("R9", 13'h0000, 16'hF030);
        msg("R2", 8'h31, 16'h0031);
        msg("R2", 8'h3F, 16'h003F);
        msg("R5", 8'h41, 16'h0041);
        rd("R2", 13'h1000 | 13'(m_ptr - 1));

        // R7: pointer cannot be written
        wr("R7", 13'h0001, 16'h0ABC);
        rd("R7", 13'h0001);

        // R8: capture and software write in one cycle
        p0 = m_ptr;
        step("R8", 1'b1, 8'h35, 16'hC0DE, 1'b1, 1'b0, 13'h1000 | 13'(p0), 16'h9999);
        rd("R8", 13'h1000 | 13'(p0));
        wr("R8", 13'h1F00, 16'h7777);
        step("R8", 1'b1, 8'h36, 16'hC1DE, 1'b1, 1'b0, 13'h1F00, 16'h8888);
        rd("R8", 13'h1F00);
        rd("R8", 13'h1000 | 13'(p0 + 1));

        // R9: message alongside a filter write sees the old filter
        step("R9", 1'b1, 8'h22, 16'h2222, 1'b1, 1'b0, 13'h0000, 16'hFF22);
        msg("R9", 8'h22, 16'h2223);
        chk("R9", "pointer after delayed filter", 32'(wr_ptr), 32'(p0 + 3));

        // R10: read of the word being filled returns old contents
        p0 = m_ptr;
        wr("R10", 13'h1000 | 13'(p0), 16'h5555);
        step("R10", 1'b1, 8'h22, 16'h6666, 1'b0, 1'b1, 13'h1000 | 13'(p0), 16'h0);
        rd("R10", 13'h1000 | 13'(p0));

        // R4: run the pointer to the top and wrap
        wr("R1", 13'h0000, 16'h0000);
        while (m_ptr != DEPTH - 1) msg("R4", m_ptr[7:0], 16'(m_ptr));
        msg("R4", 8'hAB, 16'hF00D);
        chk("R4", "pointer after wrap", 32'(wr_ptr), 32'd0);
        rd("R4", 13'h1FFF);
        msg("R4", 8'hAC, 16'hF00E);
        rd("R4", 13'h1000);

        step("R6", 1'b0, 8'h0, 16'h0, 1'b0, 1'b0, 13'h0000, 16'h0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule